// File: doc/BRIEF.md
# Core Timer with Real-Time Interrupt

A free-running counter advances on every bus clock and feeds two event sources. When its lowest eight stages wrap from all ones back to zero, an overflow flag is raised. When the counter bit picked by a two-bit rate code goes from 0 to 1, a real-time flag is raised and a one-cycle tick is sent out to an external watchdog. Each flag drives its own interrupt request through its own enable bit.

Software sees the block as a single 8-bit control/status byte at one address, reached through plain read and write strobes. The flags cannot be written directly. A flag is cleared by writing 1 to its own write-only clear bit. The counter cannot be written and keeps counting across every access. There is no streaming data path, so the block has no valid/ready handshake. All pins are plain control and status.

Top module: `rti_core_timer`

## Requirements
- R1: After reset the byte reads 0x03: both flags and both enables are 0 and both rate bits are 1. Both interrupt outputs and `wd_tick` are 0.
- R2: Bit 7 (overflow flag) becomes 1 on the clock edge where the counter's low 8 bits go from 0xFF to 0x00. This happens once every 256 clocks.
- R3: Rate code c in bits 1:0 selects counter bit TAP_LO+c (default TAP_LO=13, so bits 13 to 16). In the cycle after that bit rises, `wd_tick` is high for exactly one cycle. At the following edge, bit 6 (real-time flag) becomes 1. The tick period is 2^(TAP_LO+c+1) clocks.
- R4: `ovf_irq` is high exactly while bit 7 and bit 5 are both 1. `rti_irq` is high exactly while bit 6 and bit 4 are both 1.
- R5: A write with bit 3 set clears the overflow flag, and a write with bit 2 set clears the real-time flag. Writing 0 to these bits has no effect. The values written to bits 7 and 6 are ignored.
- R6: Bits 3 and 2 always read as 0.
- R7: Bits 5 and 4 (enables) and bits 1:0 (rate code) take the written value and read it back.
- R8: If a flag's set event and a write that clears it fall on the same edge, the flag ends up set.
- R9: Register writes never disturb the counter, so the overflow period stays 256 clocks while writes occur on every cycle.
- R10: Accesses at any address other than REG_ADDR (default 0x08) read as 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Register readback, combinational, 0 when not addressed |
| ovf_irq | output | 1 | Overflow interrupt request |
| rti_irq | output | 1 | Real-time interrupt request |
| wd_tick | output | 1 | One-cycle pulse at the selected real-time rate, for the watchdog |

## Verification
A flag's set event and a software clear of the same flag can land on the same clock edge. The bench forces this collision for both flags. For the real-time flag it issues the clear write in the cycle where `wd_tick` is seen high. For the overflow flag it times the clear write exactly 256 cycles after an observed overflow. The following read must show the flag still set. A behavioural reference model compares every output on every clock, so both the collision and ordinary clears are also checked against independently computed values.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int REG_W    = 8;
  localparam int RATE_N   = 4;
  localparam int RSEL_W   = $clog2(RATE_N);
  // bit positions software decodes
  localparam int B_OVF    = 7;
  localparam int B_RTI    = 6;
  localparam int B_OVF_EN = 5;
  localparam int B_RTI_EN = 4;
  localparam int B_OVF_CL = 3;
  localparam int B_RTI_CL = 2;
  localparam logic [REG_W-1:0] CTRL_MASK = 8'h33;
  localparam logic [REG_W-1:0] CTRL_RST  = 8'h03;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int TAP_LO     = 13,
  parameter int LOW_STAGES = 8,
  parameter int RATE_N     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              low_wrap,
  output logic [RATE_N-1:0] taps
);
  localparam int TOP_TAP = TAP_LO + RATE_N;
  localparam int CNT_W   = (TOP_TAP > LOW_STAGES) ? TOP_TAP : LOW_STAGES;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // the next edge rolls the low stages over
  assign low_wrap = &cnt[LOW_STAGES-1:0];
  assign taps     = cnt[TAP_LO +: RATE_N];

  assert_counter_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/ctm_tap_pick.sv
module ctm_tap_pick #(
  parameter int RATE_N = 4,
  parameter int RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_N-1:0] taps,
  input  logic [RSEL_W-1:0] rate_sel,
  output logic              tick
);
  logic tap_now, tap_q;

  assign tap_now = taps[rate_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= 1'b0;
    else        tap_q <= tap_now;
  end

  assign tick = tap_now & ~tap_q;

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ctm_flag.sv
module ctm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_ev)  flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_ev) |=> !flag);
  assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_req) |=> $stable(flag));
endmodule

// File: rtl/rti_core_timer.sv
module rti_core_timer #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8),
  parameter int                TAP_LO   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              ovf_irq,
  output logic              rti_irq,
  output logic              wd_tick
);
  import ctm_pkg::*;

  logic                  hit_wr, hit_rd;
  logic [REG_W-1:0]      ctrl_q;
  logic                  low_wrap, tick;
  logic [RATE_N-1:0]     taps;
  logic                  ovf_flag, rti_flag;

  assign hit_wr = wr_en && (addr == REG_ADDR);
  assign hit_rd = rd_en && (addr == REG_ADDR);

  // only enable and rate bits are stored; the rest stay zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= CTRL_RST;
    else if (hit_wr) ctrl_q <= wr_data & CTRL_MASK;
  end

  ctm_prescaler #(.TAP_LO(TAP_LO), .LOW_STAGES(8), .RATE_N(RATE_N)) u_pre (
    .clk(clk), .rst_n(rst_n), .low_wrap(low_wrap), .taps(taps)
  );

  ctm_tap_pick #(.RATE_N(RATE_N), .RSEL_W(RSEL_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .taps(taps),
    .rate_sel(ctrl_q[RSEL_W-1:0]), .tick(tick)
  );

  ctm_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .set_ev(low_wrap),
    .clr_req(hit_wr && wr_data[B_OVF_CL]), .flag(ovf_flag)
  );

  ctm_flag u_rti (
    .clk(clk), .rst_n(rst_n), .set_ev(tick),
    .clr_req(hit_wr && wr_data[B_RTI_CL]), .flag(rti_flag)
  );

  assign rd_data = hit_rd ? (ctrl_q | {ovf_flag, rti_flag, 6'b0}) : '0;
  assign ovf_irq = ovf_flag & ctrl_q[B_OVF_EN];
  assign rti_irq = rti_flag & ctrl_q[B_RTI_EN];
  assign wd_tick = tick;

  assert_clear_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[B_OVF_CL] == 1'b0 && rd_data[B_RTI_CL] == 1'b0));
  assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != REG_ADDR) |-> (rd_data == 8'h00));
endmodule

// File: tb/rti_core_timer_test.sv
`timescale 1ns/1ps
module rti_core_timer_test;
  localparam int TAP_LO = 2;
  localparam int WRAP   = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  wire  [7:0] rd_data;
  wire        ovf_irq, rti_irq, wd_tick;

  rti_core_timer #(.TAP_LO(TAP_LO)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ovf_irq(ovf_irq), .rti_irq(rti_irq),
    .wd_tick(wd_tick)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // behavioural reference model
  int       m_cnt = 0;
  bit       m_tapq = 0, m_ovf = 0, m_rti = 0;
  bit [7:0] m_ctrl = 8'h03;
  bit       mv_tap, mv_pulse, mv_ev, mv_wr;

  function automatic bit tick_of(int c, bit q, bit [1:0] rs);
    return (((c >> (TAP_LO + int'(rs))) & 1) == 1) && !q;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_tapq = 0; m_ovf = 0; m_rti = 0; m_ctrl = 8'h03;
    end else begin
      mv_tap   = ((m_cnt >> (TAP_LO + int'(m_ctrl[1:0]))) & 1) == 1;
      mv_pulse = mv_tap && !m_tapq;
      mv_ev    = (m_cnt % WRAP) == WRAP - 1;
      mv_wr    = wr_en && (addr == 8'h08);
      if (mv_ev) m_ovf = 1;
      else if (mv_wr && wr_data[3]) m_ovf = 0;
      if (mv_pulse) m_rti = 1;
      else if (mv_wr && wr_data[2]) m_rti = 0;
      if (mv_wr) m_ctrl = wr_data & 8'h33;
      m_tapq = mv_tap;
      m_cnt  = (m_cnt + 1) % WRAP;
    end
  end

  bit       e_tick;
  bit [7:0] e_rd;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      e_tick = tick_of(m_cnt, m_tapq, m_ctrl[1:0]);
      e_rd   = (rd_en && addr == 8'h08) ? (m_ctrl | {m_ovf, m_rti, 6'b0}) : 8'h00;
      chk(wd_tick == e_tick, "R3 model wd_tick", wd_tick, e_tick);
      chk(rd_data == e_rd, "R5/R7 model rd_data", rd_data, e_rd);
      chk(ovf_irq == (m_ovf & m_ctrl[5]), "R4 model ovf_irq", ovf_irq, m_ovf & m_ctrl[5]);
      chk(rti_irq == (m_rti & m_ctrl[4]), "R4 model rti_irq", rti_irq, m_rti & m_ctrl[4]);
    end
  end

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr8(input bit [7:0] d);
    addr = 8'h08; wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit [1:0] code);
    int t[3];
    int expp;
    wr8(8'h30 | 8'(code));
    for (int k = 0; k < 3; k++) begin
      while (!wd_tick) step();
      t[k] = cyc;
      step();
    end
    expp = 1 << (TAP_LO + int'(code) + 1);
    chk(t[2] - t[1] == expp, "R3 tick period", t[2] - t[1], expp);
    #1;
    chk(rti_irq == 1'b1, "R4 rti_irq after tick", rti_irq, 1);
    chk(rd_data[6] == 1'b1, "R3 rti flag set", rd_data[6], 1);
    wr8(8'h34 | 8'(code));
    #1;
    chk(rd_data[6] == 1'b0, "R5 rti flag cleared", rd_data[6], 0);
    // collision: clear write on the tick cycle
    step();
    while (!wd_tick) step();
    wr8(8'h34 | 8'(code));
    #1;
    chk(rd_data[6] == 1'b1, "R8 rti set beats clear", rd_data[6], 1);
  endtask

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_en = 1'b1; addr = 8'h08;
    #1;
    chk(rd_data == 8'h03, "R1 reset readback", rd_data, 8'h03);
    chk({ovf_irq, rti_irq, wd_tick} == 3'b000, "R1 reset outputs", {ovf_irq, rti_irq, wd_tick}, 0);

    wr8(8'hFD);
    #1;
    chk(rd_data == 8'h31, "R5/R6/R7 write 0xFD readback", rd_data, 8'h31);

    for (int c = 0; c < 4; c++) measure(2'(c));

    // overflow period under continuous writes
    wr8(8'h28);
    t1 = -1; t2 = -1;
    for (int i = 0; i < 700 && t2 < 0; i++) begin
      if (ovf_irq) begin
        if (t1 < 0) t1 = cyc; else t2 = cyc;
        wr8(8'h28);
      end else begin
        wr8(8'h20 | 8'(i % 4));
      end
    end
    chk(t2 - t1 == 256, "R2/R9 overflow period", t2 - t1, 256);

    // overflow collision
    while (!ovf_irq) step();
    wr8(8'h28);
    repeat (254) step();
    wr8(8'h28);
    #1;
    chk(rd_data[7] == 1'b1, "R8 ovf set beats clear", rd_data[7], 1);

    // enables off: flags rise, requests stay low
    wr8(8'h00);
    repeat (300) step();
    #1;
    chk(rd_data[7] == 1'b1, "R2 ovf flag with enable off", rd_data[7], 1);
    chk(rd_data[6] == 1'b1, "R3 rti flag with enable off", rd_data[6], 1);
    chk(ovf_irq == 1'b0, "R4 ovf_irq gated", ovf_irq, 0);
    chk(rti_irq == 1'b0, "R4 rti_irq gated", rti_irq, 0);

    // other address
    step();
    addr = 8'h09;
    #1;
    chk(rd_data == 8'h00, "R10 miss read", rd_data, 0);
    wr_en = 1'b1; wr_data = 8'h3F;
    step();
    wr_en = 1'b0; addr = 8'h08;
    #1;
    chk((rd_data & 8'hB3) == 8'h80, "R10 miss write ignored", rd_data & 8'hB3, 8'h80);

    step();
    finish_up();
  end
endmodule